// File: doc/BRIEF.md
# Interrupt Flag Register Bank with Read-Only Alias

This block holds the interrupt state of a two-part peripheral. Event pulses from the device logic and from the protocol controller are latched into two sticky flag registers. Software clears a latched flag by writing a one to its bit. A mask register picks which device flags may drive the interrupt line. The interrupt line is registered.

The controller flags have two addresses. Their primary address is at 0x1050, inside the controller window. A read-only alias sits at 0x0824, the word right after the device flags at 0x0820. A host that starts a two-word burst read at 0x0820 therefore receives every pending flag in one transaction. Writes to the alias do nothing, so controller flags can only be cleared at the primary address.

The register bus has byte addresses, word data, a write strobe and a read request with a burst length. The bank answers each read word one cycle later with a valid strobe, and the address steps by four for each word.

Top module: `irq_regbank`

## Requirements
- R1: A one on any bit of `dev_evt` or `ctl_evt` sets the matching flag at the next clock edge. The flag stays set until it is cleared.
- R2: If a set pulse and a write-one clear reach the same flag bit in the same cycle, the flag ends up set.
- R3: A write to 0x0820 clears each device flag whose write-data bit is 1. Device flags whose write-data bit is 0 keep their value.
- R4: The controller flags read at 0x1050. A write there clears each controller flag whose write-data bit is 1. No write to any other address clears a controller flag.
- R5: A read of 0x0824 returns the same value as a read of 0x1050. A write to 0x0824 changes no flag and no register.
- R6: When the bank is idle and `bus_re` is high, it starts a burst of `bus_len` words (a length of 0 counts as 1). It returns the words for addr, addr+4, addr+8, ... on consecutive cycles, the first one in the cycle after the request. `rd_valid` is high in exactly those cycles. A request that arrives during a burst is ignored.
- R7: The interrupt enable register at 0x0830 is fully writable, and a read returns the last value written.
- R8: `irq` is the registered OR of (device flags AND enable). It follows a change of either operand one clock cycle later.
- R9: A read of any address other than 0x0820, 0x0824, 0x0830 or 0x1050 returns zero.
- R10: Reset clears all flags, the enable register, `irq` and `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_evt | input | DW | Device event pulses, one per flag bit |
| ctl_evt | input | DW | Controller event pulses, one per flag bit |
| bus_addr | input | 16 | Byte address for a write, or the start address of a read |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read request (start of a burst) |
| bus_len | input | LEN_W | Burst length in words; 0 means 1 |
| rd_data | output | DW | Read data word |
| rd_valid | output | 1 | High when rd_data carries a burst word |
| irq | output | 1 | Registered interrupt output |

## Verification
The bound checker tests four things on every cycle:
- pulses always land in the flags, even when a clear hits the same bit;
- a controller flag never falls unless the primary clear address was written;
- `irq` tracks the masked device flags one cycle late;
- a running burst keeps `rd_valid` high, and unmapped reads return zero.

Some behaviours only the bench scenarios can show:
- the alias equals the primary register inside a two-word burst;
- alias writes are discarded;
- a length of zero yields one word, and requests during a burst are ignored;
- the enable register reads back its value.

A random phase compares every read word and the interrupt line against an independent model.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] A_DEV_FLAGS = 16'h0820;
  localparam logic [ADDR_W-1:0] A_CTL_ALIAS = 16'h0824;
  localparam logic [ADDR_W-1:0] A_IRQ_EN    = 16'h0830;
  localparam logic [ADDR_W-1:0] A_CTL_FLAGS = 16'h1050;

  typedef enum logic [1:0] {SEL_NONE, SEL_DEV, SEL_CTL, SEL_EN} rd_sel_e;

  // map a byte address onto the register it reads
  function automatic rd_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    case (a)
      A_DEV_FLAGS:              return SEL_DEV;
      A_CTL_ALIAS, A_CTL_FLAGS: return SEL_CTL;
      A_IRQ_EN:                 return SEL_EN;
      default:                  return SEL_NONE;
    endcase
  endfunction

  // burst address step: one word
  function automatic logic [ADDR_W-1:0] next_word(input logic [ADDR_W-1:0] a);
    return ADDR_W'(a + ADDR_W'(4));
  endfunction
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] flags_o
);
  // clear first, then set: a simultaneous pulse survives
  function automatic logic [W-1:0] sticky_next(input logic [W-1:0] cur,
                                               input logic [W-1:0] set,
                                               input logic [W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= sticky_next(flags_o, set_i, clr_eff);
  end
endmodule

// File: rtl/irq_read_engine.sv
module irq_read_engine
  import irq_regbank_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DW-1:0]     word_i,
  output logic [ADDR_W-1:0] lookup_addr_o,
  output logic              fire_o,
  output logic [LEN_W-1:0]  cnt_o,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o
);
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cnt;
  logic              busy;
  logic [LEN_W-1:0]  first_rem;

  assign busy          = (cnt != '0);
  assign fire_o        = busy | req_i;
  assign lookup_addr_o = busy ? cur_addr : addr_i;
  assign first_rem     = (len_i == '0) ? '0 : LEN_W'(len_i - LEN_W'(1));
  assign cnt_o         = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr   <= '0;
      cnt        <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else if (fire_o) begin
      rd_data_o  <= word_i;
      rd_valid_o <= 1'b1;
      cur_addr   <= next_word(lookup_addr_o);
      cnt        <= busy ? LEN_W'(cnt - LEN_W'(1)) : first_rem;
    end else begin
      rd_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_regbank_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     dev_evt,
  input  logic [DW-1:0]     ctl_evt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [LEN_W-1:0]  bus_len,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              irq
);
  localparam int N_GRP   = 2;
  localparam int GRP_DEV = 0;
  localparam int GRP_CTL = 1;

  // named events for the checker
  logic dev_clr_we, ctl_clr_we, en_we;
  assign dev_clr_we = bus_we && (bus_addr == A_DEV_FLAGS);
  assign ctl_clr_we = bus_we && (bus_addr == A_CTL_FLAGS);
  assign en_we      = bus_we && (bus_addr == A_IRQ_EN);

  logic [DW-1:0] grp_set   [N_GRP];
  logic          grp_clr_we[N_GRP];
  logic [DW-1:0] grp_flags [N_GRP];

  assign grp_set[GRP_DEV]    = dev_evt;
  assign grp_set[GRP_CTL]    = ctl_evt;
  assign grp_clr_we[GRP_DEV] = dev_clr_we;
  assign grp_clr_we[GRP_CTL] = ctl_clr_we;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    irq_flag_reg #(.W(DW)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (grp_set[g]),
      .clr_we_i  (grp_clr_we[g]),
      .clr_mask_i(bus_wdata),
      .flags_o   (grp_flags[g])
    );
  end

  logic [DW-1:0] dev_flags, ctl_flags, irq_en;
  assign dev_flags = grp_flags[GRP_DEV];
  assign ctl_flags = grp_flags[GRP_CTL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= '0;
      irq    <= 1'b0;
    end else begin
      if (en_we) irq_en <= bus_wdata;
      irq <= |(dev_flags & irq_en);
    end
  end

  // read path
  logic [ADDR_W-1:0] rd_lookup;
  logic              rd_fire;
  logic [LEN_W-1:0]  rd_cnt;
  logic [DW-1:0]     rd_word;
  logic              rd_addr_hit;
  rd_sel_e           rd_sel;

  assign rd_sel      = decode_sel(rd_lookup);
  assign rd_addr_hit = (rd_sel != SEL_NONE);

  always_comb begin
    case (rd_sel)
      SEL_DEV: rd_word = dev_flags;
      SEL_CTL: rd_word = ctl_flags;
      SEL_EN:  rd_word = irq_en;
      default: rd_word = '0;
    endcase
  end

  irq_read_engine #(.DW(DW), .LEN_W(LEN_W)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (bus_re),
    .addr_i       (bus_addr),
    .len_i        (bus_len),
    .word_i       (rd_word),
    .lookup_addr_o(rd_lookup),
    .fire_o       (rd_fire),
    .cnt_o        (rd_cnt),
    .rd_valid_o   (rd_valid),
    .rd_data_o    (rd_data)
  );
endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk #(
  parameter int DW    = 32,
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DW-1:0]    dev_evt,
  input logic [DW-1:0]    ctl_evt,
  input logic [DW-1:0]    dev_flags,
  input logic [DW-1:0]    ctl_flags,
  input logic [DW-1:0]    irq_en,
  input logic             irq,
  input logic             ctl_clr_we,
  input logic             rd_fire,
  input logic             rd_addr_hit,
  input logic [LEN_W-1:0] rd_cnt,
  input logic             rd_valid,
  input logic [DW-1:0]    rd_data
);
  p_dev_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_evt != '0) |=> ((dev_flags & $past(dev_evt)) == $past(dev_evt)));

  p_ctl_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_evt != '0) |=> ((ctl_flags & $past(ctl_evt)) == $past(ctl_evt)));

  p_ctl_clear_only_primary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_clr_we |=> (($past(ctl_flags) & ~ctl_flags) == '0));

  p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(dev_flags & irq_en))));

  p_burst_continues_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt != '0) |=> rd_valid);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !rd_addr_hit) |=> (rd_valid && rd_data == '0));
endmodule

bind irq_regbank irq_regbank_chk #(.DW(DW), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dev_evt    (dev_evt),
  .ctl_evt    (ctl_evt),
  .dev_flags  (dev_flags),
  .ctl_flags  (ctl_flags),
  .irq_en     (irq_en),
  .irq        (irq),
  .ctl_clr_we (ctl_clr_we),
  .rd_fire    (rd_fire),
  .rd_addr_hit(rd_addr_hit),
  .rd_cnt     (rd_cnt),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data)
);

// File: tb/tb_irq_regbank.sv
module tb_irq_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int LEN_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] dev_evt = '0, ctl_evt = '0, bus_wdata = '0;
  logic [15:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [LEN_W-1:0] bus_len = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_regbank #(.DW(DW), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .dev_evt(dev_evt), .ctl_evt(ctl_evt),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_len(bus_len), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // independent model
  logic [DW-1:0] m_dev = '0, m_ctl = '0, m_en = '0;
  logic [15:0] m_cur = '0;
  int m_rem = 0;
  logic exp_valid = 0, exp_irq = 0;
  logic [DW-1:0] exp_data = '0;
  logic [DW-1:0] cap[16];
  int cap_n = 0;

  function automatic logic [DW-1:0] model_word(input logic [15:0] a);
    if (a == 16'h0820) return m_dev;
    if (a == 16'h0824 || a == 16'h1050) return m_ctl;
    if (a == 16'h0830) return m_en;
    return '0;
  endfunction

  function automatic logic [DW-1:0] sticky(input logic [DW-1:0] cur, input logic hit,
                                           input logic [DW-1:0] wd, input logic [DW-1:0] ev);
    logic [DW-1:0] r;
    r = hit ? (cur & ~wd) : cur;
    return r | ev;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [15:0] la;
    @(posedge clk);
    if (!rst_n) begin
      m_dev = '0; m_ctl = '0; m_en = '0; m_rem = 0; m_cur = '0;
      exp_valid = 0; exp_irq = 0;
    end else begin
      exp_irq = |(m_dev & m_en);
      exp_valid = (m_rem != 0) || bus_re;
      la = (m_rem != 0) ? m_cur : bus_addr;
      exp_data = model_word(la);
      if (exp_valid) begin
        m_cur = la + 16'd4;
        if (m_rem != 0) m_rem = m_rem - 1;
        else m_rem = (bus_len == 0) ? 0 : int'(bus_len) - 1;
      end
      m_dev = sticky(m_dev, bus_we && bus_addr == 16'h0820, bus_wdata, dev_evt);
      m_ctl = sticky(m_ctl, bus_we && bus_addr == 16'h1050, bus_wdata, ctl_evt);
      if (bus_we && bus_addr == 16'h0830) m_en = bus_wdata;
    end
    #1;
    if (rst_n) begin
      check(rd_valid == exp_valid, "R6 rd_valid", DW'(rd_valid), DW'(exp_valid));
      if (exp_valid) check(rd_data == exp_data, "R6 rd_data", rd_data, exp_data);
      check(irq == exp_irq, "R8 irq", DW'(irq), DW'(exp_irq));
    end
    if (rd_valid && cap_n < 16) begin cap[cap_n] = rd_data; cap_n++; end
    @(negedge clk);
    dev_evt = '0; ctl_evt = '0; bus_we = 0; bus_re = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1; tick();
  endtask

  task automatic rd(input logic [15:0] a, input int len);
    int n;
    n = (len == 0) ? 1 : len;
    cap_n = 0;
    bus_addr = a; bus_len = LEN_W'(len); bus_re = 1; tick();
    for (int i = 1; i < n + 1; i++) tick();
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  localparam logic [15:0] ADDRS[6] = '{16'h0820, 16'h0824, 16'h0830, 16'h1050, 16'h0828, 16'h0000};

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1;
    // R10 reset state
    check(rd_valid == 0 && irq == 0, "R10 outputs after reset", DW'({rd_valid, irq}), '0);
    rd(16'h0820, 3);
    check(cap_n == 3 && cap[0] == 0 && cap[1] == 0 && cap[2] == 0, "R10 regs zero",
          cap[0] | cap[1] | cap[2], '0);
    // R1 set, R5 two-word burst with alias
    dev_evt = 32'h20; ctl_evt = 32'h204; tick();
    rd(16'h0820, 2);
    check(cap_n == 2 && cap[0] == 32'h20, "R1 dev flag set", cap[0], 32'h20);
    check(cap[1] == 32'h204, "R5 alias in burst", cap[1], 32'h204);
    rd(16'h1050, 1);
    check(cap[0] == 32'h204, "R4 primary read", cap[0], 32'h204);
    // R5 alias write ignored, R3 write-0 ignored
    wr(16'h0824, '1);
    wr(16'h0820, '0);
    rd(16'h0820, 2);
    check(cap[1] == 32'h204, "R5 alias write ignored", cap[1], 32'h204);
    check(cap[0] == 32'h20, "R3 write 0 no effect", cap[0], 32'h20);
    // R4 clear at primary, R3 clear device
    wr(16'h1050, 32'h4);
    wr(16'h0820, 32'h20);
    rd(16'h0820, 2);
    check(cap[1] == 32'h200, "R4 clear primary", cap[1], 32'h200);
    check(cap[0] == 32'h0, "R3 clear device", cap[0], 32'h0);
    // R2 set wins over clear
    dev_evt = 32'h2; tick();
    dev_evt = 32'h2; bus_addr = 16'h0820; bus_wdata = 32'h2; bus_we = 1; tick();
    ctl_evt = 32'h200; bus_addr = 16'h1050; bus_wdata = 32'h200; bus_we = 1; tick();
    rd(16'h0820, 2);
    check(cap[0] == 32'h2, "R2 dev set wins", cap[0], 32'h2);
    check(cap[1] == 32'h200, "R2 ctl set wins", cap[1], 32'h200);
    // R8 gating and lag, R7 readback
    wr(16'h0830, 32'h1);
    tick();
    check(irq == 0, "R8 masked flag", DW'(irq), 0);
    wr(16'h0830, 32'h2);
    check(irq == 0, "R8 not yet", DW'(irq), 0);
    tick();
    check(irq == 1, "R8 one cycle later", DW'(irq), 1);
    rd(16'h0830, 1);
    check(cap[0] == 32'h2, "R7 enable readback", cap[0], 32'h2);
    // R9 unmapped
    rd(16'h0828, 1);
    check(cap[0] == 0, "R9 unmapped 0x0828", cap[0], 0);
    rd(16'h2000, 1);
    check(cap[0] == 0, "R9 unmapped 0x2000", cap[0], 0);
    // R6 length zero and request during burst
    rd(16'h0830, 0);
    check(cap_n == 1, "R6 len0 one word", DW'(cap_n), 1);
    cap_n = 0;
    bus_addr = 16'h0820; bus_len = 2; bus_re = 1; tick();
    bus_addr = 16'h0830; bus_len = 3; bus_re = 1; tick();
    tick(); tick();
    check(cap_n == 2 && cap[1] == 32'h200, "R6 request during burst ignored",
          DW'(cap_n), 2);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 4 == 0) dev_evt = DW'(1) << ($urandom % DW);
      if ($urandom % 4 == 0) ctl_evt = DW'(1) << ($urandom % DW);
      if ($urandom % 4 == 0) begin
        bus_we = 1; bus_addr = ADDRS[$urandom % 6]; bus_wdata = $urandom;
      end
      if ($urandom % 3 == 0) begin
        bus_re = 1; bus_len = LEN_W'($urandom % 4);
        if (!bus_we) bus_addr = ADDRS[$urandom % 6];
      end
      tick();
    end
    finish_run();
  end
endmodule